// File: doc/BRIEF.md
# Sawtooth Watchdog Supervisor

This block drives an active-low reset line for a processor subsystem. Two conditions can hold that line low. The first is supply health. When the supply-good flag drops, reset is asserted at once. Once the flag has been high again for a fixed number of delay-oscillator periods, reset is released. Those periods arrive as single-cycle pulses on a tick input.

The second condition is a watchdog. It models a timing capacitor with an up/down counter, called the ramp. The ramp walks down slowly toward a low level. A rising edge from the host turns the ramp around so that it climbs quickly back to a high level. If the host stays silent, the ramp reaches the low level. At that point reset is held low while the ramp climbs back up, and then the cycle repeats. The counter therefore traces a sawtooth.

The ramp value and its direction are brought out for debug. Thresholds, step sizes and the delay length are parameters.

Top module: `sawtooth_wd_supervisor`

## Requirements
- R1: While `supply_ok_i` is low at a clock edge, `rst_no` is 0 after that edge.
- R2: After `supply_ok_i` returns high, `rst_no` stays low until exactly `DELAY_TICKS` (default 512) tick pulses have been seen with the flag high. It goes high on the edge after the last of those ticks. Any cycle with the flag low restarts the count.
- R3: The watchdog pin passes through a 2-flop synchronizer. A 0→1 change on the pin, seen while the ramp is discharging, makes `charging_o` read 1 after the third clock edge. A rise during charging has no effect. A pin held high has no effect.
- R4: While charging, each tick adds the charge step. When the result reaches or passes the upper level, the ramp is clamped to that level, discharging resumes, and any watchdog reset is released. `rst_no` goes high one edge later.
- R5: While discharging, a tick that would bring the ramp to or below the lower level clamps it to that level and starts charging. `rst_no` is 0 from the following edge until the edge after the upper level is reached.
- R6: While `wd_en_i` is low, and during reset, the ramp is held at the upper level with `charging_o`=0. No watchdog reset is raised or kept.
- R7: The ramp moves only on tick cycles. The charge step is `UP_STEP` (default 4) and the discharge step is `DN_STEP` (default 1). With the defaults, reset is low for one fifth of an unattended sawtooth period.
- R8: The ramp is `RAMP_W` bits wide (default 10, full scale 1023). The upper level is round(1023·47/100)=481 and the lower level is round(1023·13/100)=133.
- R9: `rst_no` is a register. It is 0 during reset. At each edge it takes the AND of supply-good, the released supply delay and the absence of a watchdog reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle pulse per delay-oscillator period |
| wd_pin_i | input | 1 | Asynchronous watchdog input from the host |
| wd_en_i | input | 1 | Watchdog enable, active high |
| supply_ok_i | input | 1 | Supply within regulation, synchronous |
| rst_no | output | 1 | Reset to the system, active low |
| ramp_o | output | RAMP_W | Current ramp value |
| charging_o | output | 1 | 1 while the ramp is charging |

## Verification
The assertions assume the following about the inputs:
- `supply_ok_i`, `wd_en_i` and `tick_i` are synchronous to the clock.
- `tick_i` is a pulse and not a level that the block must edge-detect.
- Only `wd_pin_i` may change at any time.

The stimulus drives every input on the falling clock edge, so these assumptions hold. It runs with ticks on every cycle and also with one tick every other cycle. The watchdog pin is the only input that the bench toggles without regard to the ramp phase.

// File: rtl/sawtooth_wd_pkg.sv
package sawtooth_wd_pkg;
  typedef enum logic {
    DIR_DOWN = 1'b0,
    DIR_UP   = 1'b1
  } ramp_dir_e;

  function automatic int unsigned pct_of(input int unsigned full, input int unsigned pct);
    return (full * pct + 50) / 100;
  endfunction
endpackage

// File: rtl/sawtooth_wd_sync_edge.sv
module sawtooth_wd_sync_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], async_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~prev_q;

  // R3
  rise_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/sawtooth_wd_uv_delay.sv
module sawtooth_wd_uv_delay #(
  parameter int unsigned DELAY_TICKS = 512
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic supply_ok_i,
  output logic released_o
);
  localparam int unsigned CW = (DELAY_TICKS > 1) ? $clog2(DELAY_TICKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(DELAY_TICKS - 1);

  logic [CW-1:0] cnt_q;
  logic          released_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q      <= '0;
      released_q <= 1'b0;
    end else if (!supply_ok_i) begin
      cnt_q      <= '0;
      released_q <= 1'b0;
    end else if (!released_q && tick_i) begin
      if (cnt_q == LAST) released_q <= 1'b1;
      else               cnt_q      <= cnt_q + 1'b1;
    end
  end

  assign released_o = released_q;

  // R1
  uv_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !supply_ok_i |=> !released_q);

  // R2
  uv_release_on_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(released_q) |-> $past(tick_i) && $past(supply_ok_i));
endmodule

// File: rtl/sawtooth_wd_ramp.sv
module sawtooth_wd_ramp
  import sawtooth_wd_pkg::*;
#(
  parameter int unsigned RAMP_W  = 10,
  parameter int unsigned HI_LVL  = 481,
  parameter int unsigned LO_LVL  = 133,
  parameter int unsigned UP_STEP = 4,
  parameter int unsigned DN_STEP = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              en_i,
  input  logic              kick_i,
  output logic [RAMP_W-1:0] ramp_o,
  output ramp_dir_e         dir_o,
  output logic              fault_o
);
  localparam int unsigned XW = RAMP_W + 1;
  localparam logic [RAMP_W-1:0] HI = RAMP_W'(HI_LVL);
  localparam logic [RAMP_W-1:0] LO = RAMP_W'(LO_LVL);
  localparam logic [XW-1:0] HI_X    = XW'(HI_LVL);
  localparam logic [XW-1:0] LO_DN_X = XW'(LO_LVL + DN_STEP);
  localparam logic [XW-1:0] UP_X    = XW'(UP_STEP);

  logic [RAMP_W-1:0] ramp_q, ramp_d;
  ramp_dir_e         dir_q, dir_d;
  logic              fault_q, fault_d;
  logic [XW-1:0]     ramp_x, up_sum;

  assign ramp_x = {1'b0, ramp_q};
  assign up_sum = ramp_x + UP_X;

  always_comb begin
    ramp_d  = ramp_q;
    dir_d   = dir_q;
    fault_d = fault_q;
    if (!en_i) begin
      ramp_d  = HI;
      dir_d   = DIR_DOWN;
      fault_d = 1'b0;
    end else if (dir_q == DIR_DOWN) begin
      if (kick_i) begin
        dir_d = DIR_UP;
      end else if (tick_i) begin
        if (ramp_x <= LO_DN_X) begin
          ramp_d  = LO;
          dir_d   = DIR_UP;
          fault_d = 1'b1;
        end else begin
          ramp_d = ramp_q - RAMP_W'(DN_STEP);
        end
      end
    end else if (tick_i) begin
      if (up_sum >= HI_X) begin
        ramp_d  = HI;
        dir_d   = DIR_DOWN;
        fault_d = 1'b0;
      end else begin
        ramp_d = up_sum[RAMP_W-1:0];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ramp_q  <= HI;
      dir_q   <= DIR_DOWN;
      fault_q <= 1'b0;
    end else begin
      ramp_q  <= ramp_d;
      dir_q   <= dir_d;
      fault_q <= fault_d;
    end
  end

  assign ramp_o  = ramp_q;
  assign dir_o   = dir_q;
  assign fault_o = fault_q;

  // R8
  ramp_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ramp_q >= LO && ramp_q <= HI);

  // R7
  ramp_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && en_i) |=> $stable(ramp_q));

  // R6
  disable_preset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (ramp_q == HI) && (dir_q == DIR_DOWN) && !fault_q);

  // R5
  fault_charging_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_q |-> dir_q == DIR_UP);

  // R4
  fault_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(fault_q) |-> (ramp_q == HI) || !$past(en_i));
endmodule

// File: rtl/sawtooth_wd_supervisor.sv
module sawtooth_wd_supervisor
  import sawtooth_wd_pkg::*;
#(
  parameter int unsigned RAMP_W      = 10,
  parameter int unsigned HI_PCT      = 47,
  parameter int unsigned LO_PCT      = 13,
  parameter int unsigned UP_STEP     = 4,
  parameter int unsigned DN_STEP     = 1,
  parameter int unsigned DELAY_TICKS = 512,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wd_pin_i,
  input  logic              wd_en_i,
  input  logic              supply_ok_i,
  output logic              rst_no,
  output logic [RAMP_W-1:0] ramp_o,
  output logic              charging_o
);
  localparam int unsigned FULL   = (1 << RAMP_W) - 1;
  localparam int unsigned HI_LVL = pct_of(FULL, HI_PCT);
  localparam int unsigned LO_LVL = pct_of(FULL, LO_PCT);

  logic      kick;
  logic      uv_released;
  logic      wd_fault;
  ramp_dir_e dir;
  logic      rst_q;

  sawtooth_wd_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (wd_pin_i),
    .rise_o  (kick)
  );

  sawtooth_wd_uv_delay #(.DELAY_TICKS(DELAY_TICKS)) u_uv (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick_i),
    .supply_ok_i (supply_ok_i),
    .released_o  (uv_released)
  );

  sawtooth_wd_ramp #(
    .RAMP_W  (RAMP_W),
    .HI_LVL  (HI_LVL),
    .LO_LVL  (LO_LVL),
    .UP_STEP (UP_STEP),
    .DN_STEP (DN_STEP)
  ) u_ramp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick_i),
    .en_i    (wd_en_i),
    .kick_i  (kick),
    .ramp_o  (ramp_o),
    .dir_o   (dir),
    .fault_o (wd_fault)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_q <= 1'b0;
    else         rst_q <= supply_ok_i & uv_released & ~wd_fault;
  end

  assign rst_no     = rst_q;
  assign charging_o = (dir == DIR_UP);

  // R9
  release_needs_supply_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_q) |-> $past(supply_ok_i) && $past(uv_released) && !$past(wd_fault));

  // R5
  fault_holds_reset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wd_fault |=> !rst_q);
endmodule

// File: tb/tb_sawtooth_wd_supervisor.sv
`timescale 1ns/1ps
module tb_sawtooth_wd_supervisor;
  logic       clk = 1'b0;
  logic       rst_ni, tick_i, wd_pin_i, wd_en_i, supply_ok_i;
  logic       rst_no, charging_o;
  logic [9:0] ramp_o;
  int         tests = 0;
  int         fails = 0;
  int         cyc = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  sawtooth_wd_supervisor dut (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i), .wd_pin_i(wd_pin_i),
    .wd_en_i(wd_en_i), .supply_ok_i(supply_ok_i),
    .rst_no(rst_no), .ramp_o(ramp_o), .charging_o(charging_o)
  );

  // columns: edges to advance, ramp, charging, rst_no (ticks every cycle)
  localparam int VEC [0:8][0:3] = '{
    '{  1, 480, 0, 1},
    '{ 99, 381, 0, 1},
    '{247, 134, 0, 1},
    '{  1, 133, 1, 1},
    '{  1, 137, 1, 0},
    '{ 51, 341, 1, 0},
    '{ 34, 477, 1, 0},
    '{  1, 481, 0, 0},
    '{  1, 480, 0, 1}
  };

  task automatic report();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tick_pulses(input int n);
    repeat (n) begin
      tick_i = 1'b1; @(negedge clk);
      tick_i = 1'b0; @(negedge clk);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      report();
    end
  end

  initial begin
    rst_ni = 1'b0; tick_i = 1'b1; wd_pin_i = 1'b0; wd_en_i = 1'b0; supply_ok_i = 1'b1;
    step(3);
    chk("R9 reset rst_no", rst_no, 0);
    chk("R8 reset ramp at upper level", ramp_o, 481);
    chk("R6 reset direction", charging_o, 0);
    rst_ni = 1'b1;
    step(512);
    chk("R2 still held at 512 edges", rst_no, 0);
    step(1);
    chk("R2 released after 512 ticks", rst_no, 1);

    supply_ok_i = 1'b0;
    step(1);
    chk("R1 supply drop", rst_no, 0);
    supply_ok_i = 1'b1; tick_i = 1'b0;
    tick_pulses(300);
    supply_ok_i = 1'b0;
    step(1);
    supply_ok_i = 1'b1;
    chk("R1 low during restart", rst_no, 0);
    tick_pulses(511);
    chk("R2 gated ticks, 511 seen", rst_no, 0);
    tick_pulses(1);
    chk("R2 gated ticks, 512 seen", rst_no, 1);
    chk("R6 ramp parked while disabled", ramp_o, 481);

    // R5 R4 R7: unattended sawtooth
    tick_i = 1'b1; wd_en_i = 1'b1;
    for (int i = 0; i < 9; i++) begin
      step(VEC[i][0]);
      chk($sformatf("R7 row%0d ramp", i), ramp_o, VEC[i][1]);
      chk($sformatf("R5 row%0d charging", i), charging_o, VEC[i][2]);
      chk($sformatf("R4 row%0d rst_no", i), rst_no, VEC[i][3]);
    end

    // R3 host kick
    step(200);
    chk("R7 before kick", ramp_o, 280);
    wd_pin_i = 1'b1;
    step(2);
    chk("R3 sync delay", charging_o, 0);
    step(1);
    chk("R3 kick charges", charging_o, 1);
    chk("R3 ramp held on kick edge", ramp_o, 278);
    step(10);
    wd_pin_i = 1'b0;
    step(10);
    wd_pin_i = 1'b1;
    step(30);
    chk("R3 rise while charging ignored", ramp_o, 478);
    chk("R3 still charging", charging_o, 1);
    step(1);
    chk("R4 top reached", ramp_o, 481);
    chk("R4 discharging", charging_o, 0);
    chk("R4 no reset after kick", rst_no, 1);
    step(100);
    chk("R3 held level no kick", ramp_o, 381);
    chk("R3 held level direction", charging_o, 0);

    // R6 disable during a watchdog reset
    step(250);
    chk("R5 fault ramp", ramp_o, 141);
    chk("R5 fault rst_no", rst_no, 0);
    wd_en_i = 1'b0;
    step(1);
    chk("R6 preset ramp", ramp_o, 481);
    chk("R6 preset direction", charging_o, 0);
    chk("R9 output registered", rst_no, 0);
    step(1);
    chk("R6 fault cleared", rst_no, 1);
    wd_pin_i = 1'b0; step(2); wd_pin_i = 1'b1;
    step(600);
    chk("R6 disabled no reset", rst_no, 1);
    chk("R6 disabled ramp", ramp_o, 481);
    chk("R6 disabled kick ignored", charging_o, 0);

    // R7 no tick no movement
    tick_i = 1'b0; wd_en_i = 1'b1;
    step(20);
    chk("R7 stalled without tick", ramp_o, 481);
    tick_i = 1'b1;
    step(1);
    chk("R7 one discharge step", ramp_o, 480);

    supply_ok_i = 1'b0;
    step(1);
    chk("R1 drop with watchdog on", rst_no, 0);
    done = 1'b1;
    report();
  end
endmodule